// File: doc/BRIEF.md
# Fixed Off-Time Chopper Controller

This block regulates the current in one winding of a bipolar motor bridge. While the winding is being driven, both drivers of the active diagonal pair are on. When a digital trip input reports that the current has reached its limit, the block holds the bridge in a decay state for a fixed number of clock cycles and then drives again. The decay can be slow (only the high-side source driver released), fast (both drivers released) or mixed (a fast portion of programmable length, then slow for the rest of the off-time).

Every switch of the outputs opens a blanking window of programmable length. During that window a trip is thrown away, so ringing from diode recovery or load capacitance cannot end an on-time early. The trip input comes from an asynchronous comparator and passes through a two-flop synchronizer. A disable request or a fault flag forces every output low at once. When both are released, the block starts again in the on phase with a fresh blanking window.

Top module: `fot_chopper`

## Requirements
- R1: While rst_ni is low, src_en_o, snk_en_o and blank_o are all low. On the first clock edge after release with no disable or fault, the block enters the on phase.
- R2: In the on phase, src_en_o and snk_en_o are both high until a trip is accepted. src_en_o is never high while snk_en_o is low.
- R3: An accepted trip starts an off-time of exactly off_cycles_i cycles, taken at the trip (0 counts as 1). The clock edge that ends it returns the block to the on phase.
- R4: Decay code 0 (slow), and also code 3: during the off-time src_en_o is low and snk_en_o is high.
- R5: Decay code 1 (fast): during the off-time src_en_o and snk_en_o are both low.
- R6: Decay code 2 (mixed): for the first min(fast_cycles_i, off_cycles_i) cycles of the off-time both outputs are low, and for the rest of the off-time snk_en_o is high and src_en_o is low.
- R7: Each entry into the on phase or the off-time loads a blanking window of blank_cycles_i cycles, and blank_o is high during it. A trip seen in the on phase during blanking is discarded and has no later effect.
- R8: If disable_i or fault_i is high, all three outputs are low in that same cycle. One cycle after both go low, the block is in the on phase, with blank_o high unless blank_cycles_i is 0.
- R9: The decay code is sampled when a trip is accepted. A change of decay_mode_i during an off-time takes effect only at the next off-time.
- R10: A trip_i level first sampled at clock edge k is acted on at edge k+2: src_en_o falls after edge k+2 when the block is in the on phase and not blanking.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trip_i | input | 1 | Asynchronous current-limit comparator output |
| decay_mode_i | input | 2 | Decay code: 0 slow, 1 fast, 2 mixed, 3 slow |
| disable_i | input | 1 | Output disable, active high |
| fault_i | input | 1 | Fault flag, active high |
| off_cycles_i | input | CNT_W | Fixed off-time in cycles |
| blank_cycles_i | input | CNT_W | Blanking window in cycles |
| fast_cycles_i | input | CNT_W | Fast-decay portion in mixed mode, in cycles |
| src_en_o | output | 1 | Source (high-side) driver enable |
| snk_en_o | output | 1 | Sink (low-side) driver enable |
| blank_o | output | 1 | Blanking window active |

## Verification
Two events can land in the same cycle. A synchronized trip can arrive on the exact cycle the blanking window expires. A disable or fault can change on the cycle an off-time ends. The bench sweeps the arrival of a trip pulse one cycle at a time across the blanking boundary. It also asserts and drops the fault near the last off cycle, and mixes random trips, codes and disables. A behavioural model that counts phase ages judges every cycle and decides whether the trip was discarded or accepted and which phase wins.

// File: rtl/fot_chopper_pkg.sv
package fot_chopper_pkg;

  typedef enum logic [1:0] {
    DK_SLOW  = 2'd0,
    DK_FAST  = 2'd1,
    DK_MIXED = 2'd2,
    DK_SLOW3 = 2'd3
  } decay_e;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ON   = 2'd1,
    PH_OFF  = 2'd2
  } phase_e;

endpackage

// File: rtl/fot_sync.sv
module fot_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sreg;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sreg <= '0;
    else         sreg <= {sreg[STAGES-2:0], d_i};
  end

  assign q_o = sreg[STAGES-1];
endmodule

// File: rtl/fot_blank.sv
module fot_blank #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             active_o
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt <= '0;
    else if (clr_i)         cnt <= '0;
    else if (load_i)        cnt <= len_i;
    else if (cnt != '0)     cnt <= cnt - 1'b1;
  end

  assign active_o = (cnt != '0);
endmodule

// File: rtl/fot_offtime.sv
module fot_offtime
  import fot_chopper_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] off_len_i,
  input  logic [CNT_W-1:0] fast_len_i,
  input  decay_e           mode_i,
  output logic             last_o,
  output logic             sink_on_o
);
  logic [CNT_W-1:0] off_cnt;
  logic [CNT_W-1:0] fast_cnt;
  decay_e           mode_q;
  logic [CNT_W-1:0] fast_clamped;

  // fast portion never exceeds the off-time
  assign fast_clamped = (fast_len_i > off_len_i) ? off_len_i : fast_len_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      off_cnt  <= '0;
      fast_cnt <= '0;
      mode_q   <= DK_SLOW;
    end else if (start_i) begin
      off_cnt  <= off_len_i;
      fast_cnt <= fast_clamped;
      mode_q   <= mode_i;
    end else begin
      if (off_cnt != '0)  off_cnt  <= off_cnt - 1'b1;
      if (fast_cnt != '0) fast_cnt <= fast_cnt - 1'b1;
    end
  end

  assign last_o = (off_cnt <= CNT_W'(1));

  always_comb begin
    unique case (mode_q)
      DK_FAST:  sink_on_o = 1'b0;
      DK_MIXED: sink_on_o = (fast_cnt == '0);
      default:  sink_on_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/fot_chopper.sv
module fot_chopper
  import fot_chopper_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             trip_i,
  input  logic [1:0]       decay_mode_i,
  input  logic             disable_i,
  input  logic             fault_i,
  input  logic [CNT_W-1:0] off_cycles_i,
  input  logic [CNT_W-1:0] blank_cycles_i,
  input  logic [CNT_W-1:0] fast_cycles_i,
  output logic             src_en_o,
  output logic             snk_en_o,
  output logic             blank_o
);
  phase_e phase_q, phase_d;
  logic   trip_s;
  logic   kill;
  logic   blanking;
  logic   go_off;
  logic   off_last;
  logic   off_sink;
  logic   blank_load;

  assign kill = disable_i | fault_i;

  fot_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (trip_i),
    .q_o   (trip_s)
  );

  assign go_off = (phase_q == PH_ON) && !blanking && trip_s;

  always_comb begin
    phase_d = phase_q;
    if (kill) phase_d = PH_IDLE;
    else begin
      unique case (phase_q)
        PH_IDLE: phase_d = PH_ON;
        PH_ON:   if (go_off)   phase_d = PH_OFF;
        PH_OFF:  if (off_last) phase_d = PH_ON;
        default: phase_d = PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_q <= PH_IDLE;
    else         phase_q <= phase_d;
  end

  // every switching event reloads the blanking window
  assign blank_load = !kill && (phase_d != phase_q);

  fot_blank #(.CNT_W(CNT_W)) u_blank (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (kill),
    .load_i  (blank_load),
    .len_i   (blank_cycles_i),
    .active_o(blanking)
  );

  fot_offtime #(.CNT_W(CNT_W)) u_off (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (go_off && !kill),
    .off_len_i (off_cycles_i),
    .fast_len_i(fast_cycles_i),
    .mode_i    (decay_e'(decay_mode_i)),
    .last_o    (off_last),
    .sink_on_o (off_sink)
  );

  assign src_en_o = !kill && (phase_q == PH_ON);
  assign snk_en_o = !kill && ((phase_q == PH_ON) || ((phase_q == PH_OFF) && off_sink));
  assign blank_o  = !kill && blanking;
endmodule

// File: rtl/fot_chopper_chk.sv
module fot_chopper_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             disable_i,
  input logic             fault_i,
  input logic [CNT_W-1:0] blank_cycles_i,
  input logic             src_en_o,
  input logic             snk_en_o,
  input logic             blank_o
);
  logic kill;
  assign kill = disable_i | fault_i;

  a_r2_src_needs_snk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    src_en_o |-> snk_en_o);

  a_r8_kill_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kill |-> (!src_en_o && !snk_en_o && !blank_o));

  a_r7_blank_holds_on: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_en_o && blank_o) |=> (src_en_o || disable_i || fault_i));

  a_r8_release_blanked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(kill) && !kill) |=>
      (kill || (src_en_o && (blank_o || ($past(blank_cycles_i) == '0)))));
endmodule

bind fot_chopper fot_chopper_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .disable_i     (disable_i),
  .fault_i       (fault_i),
  .blank_cycles_i(blank_cycles_i),
  .src_en_o      (src_en_o),
  .snk_en_o      (snk_en_o),
  .blank_o       (blank_o)
);

// File: tb/fot_chopper_tb.sv
`timescale 1ns/1ps
module fot_chopper_tb;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         trip = 1'b0;
  logic [1:0]   mode = 2'd0;
  logic         dis = 1'b0;
  logic         flt = 1'b0;
  logic [W-1:0] off_c = 8'd6;
  logic [W-1:0] blk_c = 8'd3;
  logic [W-1:0] fst_c = 8'd2;
  logic         src, snk, blk;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  fot_chopper #(.CNT_W(W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .trip_i(trip), .decay_mode_i(mode),
    .disable_i(dis), .fault_i(flt), .off_cycles_i(off_c),
    .blank_cycles_i(blk_c), .fast_cycles_i(fst_c),
    .src_en_o(src), .snk_en_o(snk), .blank_o(blk)
  );

  // behavioural reference: phase ages, captured lengths
  int m_ph, m_on_age, m_dec_age, m_blen, m_dlen, m_flen, m_mode;
  bit m_s1, m_s2;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = 0; m_on_age = 0; m_dec_age = 0; m_blen = 0;
      m_dlen = 1; m_flen = 0; m_mode = 0; m_s1 = 0; m_s2 = 0;
    end else begin
      bit seen;
      seen = m_s2; m_s2 = m_s1; m_s1 = trip;
      if (dis || flt) m_ph = 0;
      else if (m_ph == 0) begin
        m_ph = 1; m_on_age = 0; m_blen = int'(blk_c);
      end else if (m_ph == 1) begin
        if (m_on_age >= m_blen && seen) begin
          m_ph = 2; m_dec_age = 0;
          m_dlen = (off_c == 0) ? 1 : int'(off_c);
          m_flen = (fst_c > off_c) ? int'(off_c) : int'(fst_c);
          m_mode = int'(mode); m_blen = int'(blk_c);
        end else m_on_age++;
      end else begin
        if (m_dec_age == m_dlen - 1) begin
          m_ph = 1; m_on_age = 0; m_blen = int'(blk_c);
        end else m_dec_age++;
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    int es, ek, eb;
    string tag;
    if (!rst_n)              begin es = 0; ek = 0; eb = 0; tag = "R1"; end
    else if (dis || flt)     begin es = 0; ek = 0; eb = 0; tag = "R8"; end
    else if (m_ph == 0)      begin es = 0; ek = 0; eb = 0; tag = "R1"; end
    else if (m_ph == 1) begin
      es = 1; ek = 1; eb = (m_on_age < m_blen) ? 1 : 0;
      tag = eb ? "R7" : "R2";
    end else begin
      es = 0; eb = (m_dec_age < m_blen) ? 1 : 0;
      if (m_mode == 1)      begin ek = 0; tag = "R5"; end
      else if (m_mode == 2) begin ek = (m_dec_age >= m_flen) ? 1 : 0; tag = "R6"; end
      else                  begin ek = 1; tag = "R4"; end
    end
    chk(tag, {29'd0, src, snk, blk}, (es << 2) | (ek << 1) | eb);
  endtask

  task automatic tick();
    @(negedge clk);
    compare();
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic pulse_trip();
    trip = 1'b1; tick(); trip = 1'b0;
  endtask

  // count cycles src stays low from a negedge where it is already low
  task automatic count_off(output int n);
    n = 0;
    while (!src && n < 300) begin n++; tick(); end
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int n;
    logic [15:0] lf;
    ticks(3);
    chk("R1 reset src", src, 0); chk("R1 reset snk", snk, 0); chk("R1 reset blank", blk, 0);
    rst_n = 1'b1;
    tick();
    chk("R1 first on", src, 1);
    ticks(6);

    // R10 latency and R3 off length, slow decay (R4)
    trip = 1'b1; tick(); trip = 1'b0;
    chk("R10 edge k", src, 1);
    tick(); chk("R10 edge k+1", src, 1);
    tick(); chk("R10 edge k+2", src, 0);
    chk("R4 slow snk", snk, 1);
    count_off(n); chk("R3 off length 6", n, 6);
    ticks(5);

    // fast decay
    mode = 2'd1; pulse_trip(); ticks(2);
    chk("R5 fast snk", snk, 0);
    ticks(10);
    // mixed, in range / clamped / zero
    mode = 2'd2; fst_c = 8'd2; pulse_trip(); ticks(14);
    fst_c = 8'd9; pulse_trip(); ticks(14);
    fst_c = 8'd0; pulse_trip(); ticks(14);
    mode = 2'd3; pulse_trip(); ticks(2); chk("R4 code3 snk", snk, 1); ticks(10);

    // off-time of zero counts as one
    mode = 2'd0; off_c = 8'd0; pulse_trip(); ticks(2);
    count_off(n); chk("R3 off length 0->1", n, 1);
    off_c = 8'd6; ticks(4);

    // R9: mode change mid off-time
    mode = 2'd1; pulse_trip(); ticks(3);
    mode = 2'd0; tick(); chk("R9 latched fast", snk, 0);
    ticks(2); chk("R9 latched fast late", snk, 0);
    ticks(6);
    pulse_trip(); ticks(2); chk("R9 new slow", snk, 1); ticks(8);

    // R7: trip inside blanking is discarded
    blk_c = 8'd8; dis = 1'b1; tick(); dis = 1'b0; tick();
    chk("R8 release on", src, 1); chk("R8 release blank", blk, 1);
    pulse_trip(); n = 0;
    for (int i = 0; i < 12; i++) begin tick(); if (!src) n++; end
    chk("R7 discarded trip", n, 0);

    // trip arrival swept across the blanking boundary
    blk_c = 8'd3;
    for (int d = 0; d < 7; d++) begin
      flt = 1'b1; tick(); flt = 1'b0;
      ticks(d); pulse_trip(); ticks(12);
    end

    // R8 fault mid off-time: outputs drop same cycle
    mode = 2'd0; pulse_trip(); ticks(3);
    flt = 1'b1; #1;
    chk("R8 fault src", src, 0); chk("R8 fault snk", snk, 0); chk("R8 fault blank", blk, 0);
    ticks(3); flt = 1'b0; ticks(3);
    // fault on the last off cycle
    pulse_trip(); ticks(2 + 5); flt = 1'b1; tick(); flt = 1'b0; ticks(6);
    // disable held while trips toggle
    dis = 1'b1; trip = 1'b1; ticks(6); chk("R8 disabled snk", snk, 0); dis = 1'b0;
    // continuous trip, no blanking
    blk_c = 8'd0; ticks(30); trip = 1'b0; blk_c = 8'd3;

    // random mix
    lf = 16'hACE1;
    for (int i = 0; i < 4000; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      trip = lf[0] & lf[3];
      if (lf[9:6] == 4'h0) mode = lf[5:4];
      dis = (lf[15:11] == 5'h00);
      flt = (lf[15:11] == 5'h1F);
      if (lf[14:8] == 7'h11) begin
        off_c = {4'd0, lf[3:0]}; blk_c = {5'd0, lf[6:4]}; fst_c = {4'd0, lf[11:8]};
      end
      tick();
    end
    trip = 1'b0; dis = 1'b0; flt = 1'b0;
    ticks(4);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule